// File: doc/BRIEF.md
# Multiplexed ADC Monitoring Sequencer

This block scans a bank of analog monitoring channels (regulator voltages, regulator currents, board temperatures) that reach a single pipelined ADC through several 8-to-1 analog multiplexers. The multiplexers share one 3-bit select bus and one output node, so the sequencer drives the select bus and a separate enable for each multiplexer. It keeps at most one enable high, and it turns all enables off for one ADC clock whenever the scan moves from one multiplexer to the next. It also divides the system clock to produce the ADC clock, with a ratio that can be programmed.

The ADC returns each word five ADC clocks after it sampled the input. After every channel change the sequencer therefore waits a programmable settle count plus the pipeline latency. It then takes exactly one word and writes it into a sample RAM at the address equal to the channel index {mux, select}. A separate synchronous read port gives access to the stored samples. When the last channel is stored, the block pulses a frame-done flag. While `run` stays high, scanning restarts at channel 0. When `run` is low, the block returns to idle.

The controller has three states. SCAN_IDLE has all enables low. On an ADC tick with `run` high it latches the settle count, points at channel 0 and goes to SCAN_GAP. SCAN_GAP holds all enables low for one ADC tick and then goes to SCAN_DWELL, which turns on the enable for the current channel. SCAN_DWELL counts ticks. On the capture tick it stores the word and steps the channel. If the next channel is on the same multiplexer it stays in SCAN_DWELL. If the next channel is on another multiplexer it goes to SCAN_GAP. After the last channel it goes to SCAN_GAP when `run` is high, and to SCAN_IDLE when `run` is low.

Top module: `adc_scan_seq`

## Requirements
- R1: While `rst_n` is low, `adc_clk`, every bit of `mux_en` and `frame_done` are 0.
- R2: `adc_clk` has a period of `div_ratio` system clocks and stays high for floor(`div_ratio`/2) of them; a ratio below 2 is treated as 2.
- R3: At most one bit of `mux_en` is high in any cycle.
- R4: Between the last channel of one multiplexer and the first channel of the next (including the wrap from channel 31 to channel 0 while running), all enables are low for exactly one rising edge of `adc_clk`.
- R5: Channels are visited in ascending order 0..31. The channel index is {multiplexer number (bits 4:3), `mux_sel` (bits 2:0)}, and `mux_en` bit m selects multiplexer m. Every scan that starts from idle begins at channel 0.
- R6: Each channel stays selected for exactly settle + 6 rising edges of `adc_clk`, where settle is the value of `settle_cycles` latched when the scan started.
- R7: RAM address c holds the ADC word that leaves the pipeline on the capture tick of channel c. That word is the input sampled on the (settle+1)-th rising edge after channel c was selected, because the ADC latency is 5 edges. `rd_data` shows the entry at `rd_addr` one system clock after the address is applied.
- R8: `frame_done` is a single-cycle pulse after channel 31 is stored. While running continuously, consecutive pulses are (32·(settle+6)+4)·ratio system clocks apart.
- R9: When `run` goes low mid-scan, the current scan completes with one more `frame_done`. After that, all enables stay low and no further pulse occurs.
- R10: `mux_en` and `mux_sel` change only on the system clock edge at which `adc_clk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan enable; sampled at the end of each scan |
| div_ratio | input | DIV_W (8) | ADC clock divide ratio, applied at the next ADC period |
| settle_cycles | input | SETTLE_W (4) | Extra ADC clocks to discard after a channel change |
| adc_data | input | DATA_W (10) | ADC output word |
| adc_clk | output | 1 | Divided ADC clock |
| mux_sel | output | SEL_W (3) | Select lines shared by all multiplexers |
| mux_en | output | NUM_MUX (4) | One enable per multiplexer |
| rd_addr | input | CH_W (5) | Sample RAM read address (channel index) |
| rd_data | output | DATA_W (10) | Sample RAM read data, one cycle after address |
| frame_done | output | 1 | One-cycle pulse at the end of a complete scan |

## Verification
The hardest thing to show from the ports is that the stored word belongs to the correct ADC sample and not to a neighbouring one, because every word from a steady channel looks alike. The bench's ADC model therefore encodes into each word both the channel it saw and the number of ADC edges since that channel was selected. A stored value other than {channel, settle} reveals an error in the latency or settle count. The same model also drives the multiplexer-to-multiplexer gaps and the channel 31 to 0 wrap. It is run under three divide/settle pairs, including a clamped ratio and the largest settle count, and each run is stopped mid-scan so that the drain to idle is exercised.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_GAP   = 2'd1,
        SCAN_DWELL = 2'd2
    } scan_state_t;

endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             adc_clk,
    output logic             fall_now
);

    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nx;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        div_eff  = (div_ratio < MIN_DIV) ? MIN_DIV : div_ratio;
        half     = div_q >> 1;
        cnt_nx   = (cnt_q >= div_q - ONE) ? '0 : cnt_q + ONE;
        fall_now = (cnt_nx == half);
    end

    // Period restarts when the count wraps; a new ratio is taken there.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= ONE;
            div_q   <= MIN_DIV;
            adc_clk <= 1'b0;
        end else begin
            cnt_q   <= cnt_nx;
            adc_clk <= (cnt_nx < half);
            if (cnt_nx == '0) begin
                div_q <= div_eff;
            end
        end
    end

endmodule

// File: rtl/adc_sample_ram.sv
`timescale 1ns/1ps
module adc_sample_ram #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/adc_scan_fsm.sv
`timescale 1ns/1ps
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int CH_W     = 5,
    parameter int SETTLE_W = 4,
    parameter int ADC_LAT  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                run,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [CH_W-1:0]     ch,
    output logic                drive,
    output logic                wr_en,
    output logic                frame_done
);

    localparam int               CNT_W   = $clog2((1 << SETTLE_W) + ADC_LAT + 1);
    localparam logic [CH_W-1:0]  LAST_CH = '1;

    scan_state_t         state_q;
    scan_state_t         state_d;
    logic [CH_W-1:0]     ch_q;
    logic                drive_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                done_q;

    logic at_capture;
    logic capture;
    logic last_ch;
    logic mux_edge;

    always_comb begin
        at_capture = (cnt_q == CNT_W'(settle_q) + CNT_W'(ADC_LAT));
        capture    = tick && (state_q == SCAN_DWELL) && at_capture;
        last_ch    = (ch_q == LAST_CH);
        mux_edge   = &ch_q[SEL_W-1:0];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (tick && run) state_d = SCAN_GAP;
            end
            SCAN_GAP: begin
                if (tick) state_d = SCAN_DWELL;
            end
            SCAN_DWELL: begin
                if (capture) begin
                    if (last_ch)       state_d = run ? SCAN_GAP : SCAN_IDLE;
                    else if (mux_edge) state_d = SCAN_GAP;
                    else               state_d = SCAN_DWELL;
                end
            end
            default: state_d = SCAN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q     <= '0;
            drive_q  <= 1'b0;
            cnt_q    <= '0;
            settle_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= capture && last_ch;
            unique case (state_q)
                SCAN_IDLE: begin
                    drive_q <= 1'b0;
                    if (tick && run) begin
                        ch_q     <= '0;
                        settle_q <= settle_cycles;
                    end
                end
                SCAN_GAP: begin
                    if (tick) begin
                        drive_q <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
                SCAN_DWELL: begin
                    if (capture) begin
                        ch_q  <= ch_q + 1'b1;
                        cnt_q <= '0;
                        if (mux_edge) drive_q <= 1'b0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: drive_q <= 1'b0;
            endcase
        end
    end

    assign ch         = ch_q;
    assign drive      = drive_q;
    assign wr_en      = capture;
    assign frame_done = done_q;

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
    parameter int NUM_MUX  = 4,
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 10,
    parameter int ADC_LAT  = 5,
    parameter int DIV_W    = 8,
    parameter int SETTLE_W = 4,
    parameter int MUX_W    = $clog2(NUM_MUX),
    parameter int CH_W     = MUX_W + SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_W-1:0]    div_ratio,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [DATA_W-1:0]   adc_data,
    output logic                adc_clk,
    output logic [SEL_W-1:0]    mux_sel,
    output logic [NUM_MUX-1:0]  mux_en,
    input  logic [CH_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                frame_done
);

    logic            fall_now;
    logic [CH_W-1:0] ch;
    logic            drive;
    logic            wr_en;

    adc_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .adc_clk   (adc_clk),
        .fall_now  (fall_now)
    );

    adc_scan_fsm #(
        .SEL_W    (SEL_W),
        .CH_W     (CH_W),
        .SETTLE_W (SETTLE_W),
        .ADC_LAT  (ADC_LAT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (fall_now),
        .run           (run),
        .settle_cycles (settle_cycles),
        .ch            (ch),
        .drive         (drive),
        .wr_en         (wr_en),
        .frame_done    (frame_done)
    );

    adc_sample_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (CH_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (ch),
        .wr_data (adc_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign mux_sel = ch[SEL_W-1:0];

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_en
        assign mux_en[m] = drive && (ch[CH_W-1:SEL_W] == MUX_W'(m));
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
    parameter int NUM_MUX = 4,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adc_clk,
    input logic [SEL_W-1:0]   mux_sel,
    input logic [NUM_MUX-1:0] mux_en,
    input logic               frame_done
);

    // R3
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mux_en));

    // R10
    sel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mux_en) || !$stable(mux_sel)) |-> $fell(adc_clk));

    // R4
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en != '0 && $past(mux_en) != '0) |-> (mux_en == $past(mux_en)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
    .NUM_MUX (NUM_MUX),
    .SEL_W   (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_clk    (adc_clk),
    .mux_sel    (mux_sel),
    .mux_en     (mux_en),
    .frame_done (frame_done)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;

    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] div_ratio = 8'd4;
    logic [3:0] settle_cycles = 4'd2;
    logic [9:0] adc_data = '0;
    logic       adc_clk;
    logic [2:0] mux_sel;
    logic [3:0] mux_en;
    logic [4:0] rd_addr = '0;
    logic [9:0] rd_data;
    logic       frame_done;

    int checks = 0;
    int errors = 0;
    int exp_div = 4;
    int exp_s = 2;
    int epoch = 0;
    int fd_count = 0;

    adc_scan_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .div_ratio     (div_ratio),
        .settle_cycles (settle_cycles),
        .adc_data      (adc_data),
        .adc_clk       (adc_clk),
        .mux_sel       (mux_sel),
        .mux_en        (mux_en),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .frame_done    (frame_done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural ADC and reference model, evaluated every clock
    int       cyc = 0;
    logic     prev_adc = 1'b0;
    logic [3:0] prev_en = '0;
    logic [2:0] prev_sel = '0;
    logic     prev_fd = 1'b0;
    int       cur_ch = -1;
    int       last_ch = 0;
    bit       order_valid = 0;
    int       dwell = 0;
    int       gap = 0;
    int       last_rise = 0;
    int       cfg_rises = 0;
    int       seen_epoch = 0;
    int       last_fd = 0;
    bit       fd_valid = 0;
    int       age = 0;
    int       last_key = -1;
    int       adc_q[$];

    always @(negedge clk) begin
        int  new_ch, idx, key, val;
        bit  rise, fall;
        cyc++;
        if (!rst_n) begin
            adc_q.delete();
            cur_ch = -1;
            order_valid = 0;
        end else begin
            if (epoch != seen_epoch) begin
                seen_epoch = epoch;
                cfg_rises = 0;
                fd_valid = 0;
            end
            rise = adc_clk && !prev_adc;
            fall = !adc_clk && prev_adc;
            idx = 0;
            for (int m = 0; m < 4; m++) if (mux_en[m]) idx = m;
            // R3
            chk($countones(mux_en) <= 1, "R3", $countones(mux_en), 1);
            if (mux_en == 0) new_ch = -1;
            else new_ch = idx * 8 + int'(mux_sel);
            // R10
            if (mux_en != prev_en || mux_sel != prev_sel)
                chk(fall, "R10", int'(fall), 1);
            if (rise) begin
                // R2 period
                if (cfg_rises >= 3) chk(cyc - last_rise == exp_div, "R2", cyc - last_rise, exp_div);
                last_rise = cyc;
                cfg_rises++;
                key = {mux_en, mux_sel};
                if (key != last_key) age = 0;
                else if (age < 31) age++;
                last_key = key;
                if (mux_en == 0) val = 10'h3FF;
                else if ($countones(mux_en) > 1) val = 10'h2AA;
                else val = (new_ch << 5) | age;
                adc_q.push_back(val);
                if (adc_q.size() > LAT) adc_data = 10'(adc_q.pop_front());
                if (cur_ch >= 0) dwell++;
                else gap++;
            end
            // R2 high time
            if (fall && cfg_rises >= 3)
                chk(cyc - last_rise == exp_div / 2, "R2", cyc - last_rise, exp_div / 2);
            if (new_ch != cur_ch) begin
                if (cur_ch >= 0) chk(dwell == exp_s + 6, "R6", dwell, exp_s + 6);
                if (new_ch >= 0) begin
                    if (order_valid) chk(new_ch == (last_ch + 1) % 32, "R5", new_ch, (last_ch + 1) % 32);
                    else chk(new_ch == 0, "R5", new_ch, 0);
                    if (cur_ch == -1 && order_valid) chk(gap == 1, "R4", gap, 1);
                    last_ch = new_ch;
                    order_valid = 1;
                end
                dwell = 0;
                gap = 0;
                cur_ch = new_ch;
            end
            if (frame_done) begin
                fd_count++;
                // R8 single-cycle pulse
                chk(!prev_fd, "R8", int'(prev_fd), 0);
                if (fd_valid)
                    chk(cyc - last_fd == (32 * (exp_s + 6) + 4) * exp_div, "R8",
                        cyc - last_fd, (32 * (exp_s + 6) + 4) * exp_div);
                last_fd = cyc;
                fd_valid = run;
                if (!run) order_valid = 0;
            end
            if (!run) fd_valid = 0;
        end
        prev_adc = adc_clk;
        prev_en  = mux_en;
        prev_sel = mux_sel;
        prev_fd  = frame_done;
    end

    task automatic set_cfg(input int d, input int s);
        div_ratio = 8'(d);
        settle_cycles = 4'(s);
        exp_div = (d < 2) ? 2 : d;
        exp_s = s;
        epoch++;
    endtask

    task automatic wait_fd(input int target);
        while (fd_count < target) @(negedge clk);
    endtask

    task automatic idle_watch(input int n);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (mux_en != 0 || frame_done) bad++;
        end
        // R9 no enables and no pulse after the drain
        chk(bad == 0, "R9", bad, 0);
    endtask

    task automatic ram_check(input int s);
        for (int c = 0; c < 32; c++) begin
            rd_addr = 5'(c);
            @(negedge clk);
            // R7 stored word is {channel, settle}
            chk(rd_data == 10'((c << 5) | s), "R7", int'(rd_data), (c << 5) | s);
        end
    endtask

    task automatic run_phase(input int d, input int s, input int frames);
        int base;
        set_cfg(d, s);
        base = fd_count;
        run = 1'b1;
        wait_fd(base + frames);
        repeat (60) @(negedge clk);
        run = 1'b0;
        wait_fd(base + frames + 1);
        idle_watch(400);
        ram_check(s);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk(adc_clk == 1'b0, "R1", int'(adc_clk), 0);
        chk(mux_en == 4'b0, "R1", int'(mux_en), 0);
        chk(frame_done == 1'b0, "R1", int'(frame_done), 0);
        rst_n = 1'b1;
        idle_watch(40);
        run_phase(4, 2, 2);
        run_phase(6, 0, 1);
        run_phase(0, 15, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", fd_count, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule